// File: doc/BRIEF.md
# Dual-Window GPIO Port Register Block

This block is the register file and pad-control logic for one general-purpose I/O port. A simple valid/ready bus reaches it through two address windows. Both windows decode the same register offsets. The slow window finishes each access in two cycles. The fast window finishes an access in the cycle it is presented. An external per-port select input decides which window is live. An access to the other window completes with normal timing, reads zero and changes nothing. A port clock-enable input gates every access in the same way.

The block holds seven configuration registers: output data, direction, alternate-function select, digital enable, open-drain, pull-up and pull-down. From them it computes, for each pin, the pad output-enable, the pad output value and the pull requests. Pins handed to a peripheral take their enable and value from the peripheral. A synchronised copy of the input pins is readable. Four read-only identification words let software recognise the port.

At reset every pin is undriven, except a set of debug pins. Those pins come up already handed to their peripheral and digitally enabled.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset the alternate-select and digital-enable registers equal DEBUG_MASK (default 8'h0F) and the direction, open-drain, pull-up, pull-down and output-data registers are zero, so only debug pins can drive.
- R2: Address bit 7 set selects the fast window (bit 7 clear selects the slow window), and the register index is address bits 6:2. A fast-window request with no slow access pending sees req_ready in the same cycle, and a write takes effect at that clock edge.
- R3: A slow-window request sees req_ready low in its first cycle and high in the second. No new request is accepted while a slow access is pending.
- R4: When win_fast_sel (1 = fast window live, 0 = slow window live) does not match the addressed window, the access reads zero and writes nothing. It still completes with the latency of the window addressed.
- R5: While clk_en is low, every access reads zero and writes nothing, with normal latency.
- R6: Register indices are 0 data, 1 direction, 2 alternate select, 3 digital enable, 4 open-drain, 5 pull-up, 6 pull-down. Indices 1 to 6 read back the low N_PINS bits last written. Other unmapped indices read zero and ignore writes.
- R7: A pin with digital enable 1, alternate select 0, direction 1 and open-drain 0 drives pad_oe=1 and pad_out equal to its data bit. With direction 0 it does not drive.
- R8: In open-drain mode (digital enable 1, alternate 0, direction 1, open-drain 1), pad_oe is the inverse of the data bit and pad_out is 0.
- R9: With alternate select 1 and digital enable 1, pad_oe and pad_out follow alt_oe and alt_out, and the direction and open-drain bits are ignored.
- R10: With digital enable 0 the pin neither drives nor requests a pull. Otherwise pad_pu and pad_pd equal the pull-up and pull-down bits.
- R11: Indices 8 to 11 read ID_MAGIC OR k (k = 0..3, default ID_MAGIC 32'h4750_0000). Writes to them have no effect.
- R12: A read of index 0 returns pin_in as sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Port clock enable; low blocks all access |
| win_fast_sel | input | 1 | 1: fast window live, 0: slow window live |
| req_valid | input | 1 | Request valid, held until req_ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Bit 7 window, bits 6:2 register index |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access completes at this clock edge |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| pin_in | input | N_PINS | Pin input levels |
| alt_oe | input | N_PINS | Peripheral output enable per pin |
| alt_out | input | N_PINS | Peripheral output value per pin |
| pad_oe | output | N_PINS | Pad output enable |
| pad_out | output | N_PINS | Pad output value |
| pad_pu | output | N_PINS | Pull-up request |
| pad_pd | output | N_PINS | Pull-down request |

## Verification
The assertions check the handshake timing on every cycle: same-cycle ready on the fast window, the single wait state on the slow window, and the end of a pending access. They also check zero read data from a dark window on fast accesses, register stability while the clock enable is low, and the pad invariants: no drive or pull without digital enable, and no high level in open-drain mode. Other behaviour can only be shown by the bench scenarios. These are the reset values of the debug pins, the actual read-back of every register through every window/select/enable combination, and the identification values. The bench also sweeps the full pad truth table with the peripheral inputs set differently on each pin.

// File: rtl/gpio_dp_pkg.sv
// Shared constants for the dual-window GPIO port: register indices,
// identification bank size and the bus data width.
package gpio_dp_pkg;
    localparam int BUS_W    = 32;
    localparam int IX_DATA  = 0;
    localparam int IX_DIR   = 1;
    localparam int IX_ALT   = 2;
    localparam int IX_DEN   = 3;
    localparam int IX_ODR   = 4;
    localparam int IX_PUP   = 5;
    localparam int IX_PDN   = 6;
    localparam int NCFG     = 6;   // indices 1..6 are plain config registers
    localparam int IX_ID0   = 8;
    localparam int ID_COUNT = 4;
endpackage

// File: rtl/gpio_dp_bus.sv
// Bus front end. Turns valid/ready requests from either window into one
// register access per request. Fast-window requests complete combinationally.
// Slow-window requests are captured and complete one cycle later.
// Assumes the master holds its request stable until req_ready.
module gpio_dp_bus #(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 3,
    localparam int DW    = gpio_dp_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             win_fast_sel,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    rd_value,
    output logic             req_ready,
    output logic [DW-1:0]    rsp_rdata,
    output logic             acc_wr,
    output logic [IDX_W-1:0] acc_idx,
    output logic [DW-1:0]    acc_wdata,
    output logic             leg_busy
);
    logic             addr_fast;
    logic [IDX_W-1:0] addr_idx;
    logic             live_now;
    logic             fast_now;
    logic             leg_start;
    logic             p_write;
    logic             p_live;
    logic [IDX_W-1:0] p_idx;
    logic [DW-1:0]    p_wdata;

    assign addr_fast = req_addr[ADDR_W-1];
    assign addr_idx  = req_addr[ADDR_W-2:2];
    assign live_now  = clk_en && (addr_fast == win_fast_sel);
    assign fast_now  = req_valid && !leg_busy && addr_fast;
    assign leg_start = req_valid && !leg_busy && !addr_fast;

    // Capture a slow-window request and hold it for its completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_busy <= 1'b0;
            p_write  <= 1'b0;
            p_live   <= 1'b0;
            p_idx    <= '0;
            p_wdata  <= '0;
        end else if (leg_start) begin
            leg_busy <= 1'b1;
            p_write  <= req_write;
            p_live   <= live_now;
            p_idx    <= addr_idx;
            p_wdata  <= req_wdata;
        end else if (leg_busy) begin
            leg_busy <= 1'b0;
        end
    end

    // Select which request drives the register file this cycle.
    always_comb begin
        acc_idx   = leg_busy ? p_idx : addr_idx;
        acc_wdata = leg_busy ? p_wdata : req_wdata;
        acc_wr    = 1'b0;
        rsp_rdata = '0;
        req_ready = fast_now || leg_busy;
        if (fast_now) begin
            acc_wr = req_write && live_now;
            if (live_now) rsp_rdata = rd_value;
        end else if (leg_busy) begin
            acc_wr = p_write && p_live;
            if (p_live) rsp_rdata = rd_value;
        end
    end
endmodule

// File: rtl/gpio_dp_regs.sv
// Register file: output data, six configuration registers, an input
// synchroniser stage and the read-only identification bank.
// Assumes N_PINS <= 32 and indices as defined in gpio_dp_pkg.
module gpio_dp_regs #(
    parameter int               N_PINS     = 8,
    parameter int               IDX_W      = 5,
    parameter logic [N_PINS-1:0] DEBUG_MASK = N_PINS'(4'hF),
    parameter logic [31:0]      ID_MAGIC   = 32'h4750_0000,
    localparam int              DW         = gpio_dp_pkg::BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DW-1:0]     acc_wdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [DW-1:0]     rd_value,
    output logic [N_PINS-1:0] q_data,
    output logic [N_PINS-1:0] q_dir,
    output logic [N_PINS-1:0] q_alt,
    output logic [N_PINS-1:0] q_den,
    output logic [N_PINS-1:0] q_odr,
    output logic [N_PINS-1:0] q_pup,
    output logic [N_PINS-1:0] q_pdn
);
    import gpio_dp_pkg::*;

    logic [N_PINS-1:0] cfg_q [NCFG];
    logic [N_PINS-1:0] pin_q;
    int unsigned       idx_u;

    assign idx_u = 32'(acc_idx);

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          q_data <= '0;
        else if (acc_wr && idx_u == IX_DATA) q_data <= acc_wdata[N_PINS-1:0];
    end

    // Configuration registers; debug pins reset into alternate, enabled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCFG; k++) begin
                cfg_q[k] <= ((k + 1 == IX_ALT) || (k + 1 == IX_DEN)) ? DEBUG_MASK : '0;
            end
        end else if (acc_wr) begin
            for (int k = 0; k < NCFG; k++) begin
                if (idx_u == 32'(k + 1)) cfg_q[k] <= acc_wdata[N_PINS-1:0];
            end
        end
    end

    // One-stage sample of the input pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_in;
    end

    assign q_dir = cfg_q[IX_DIR-1];
    assign q_alt = cfg_q[IX_ALT-1];
    assign q_den = cfg_q[IX_DEN-1];
    assign q_odr = cfg_q[IX_ODR-1];
    assign q_pup = cfg_q[IX_PUP-1];
    assign q_pdn = cfg_q[IX_PDN-1];

    // Read multiplexer over pins, config registers and identification words.
    always_comb begin
        rd_value = '0;
        if (idx_u == IX_DATA) begin
            rd_value[N_PINS-1:0] = pin_q;
        end else if (idx_u >= 1 && idx_u <= NCFG) begin
            rd_value[N_PINS-1:0] = cfg_q[idx_u-1];
        end else if (idx_u >= IX_ID0 && idx_u < IX_ID0 + ID_COUNT) begin
            rd_value = ID_MAGIC | (idx_u - IX_ID0);
        end
    end
endmodule

// File: rtl/gpio_dp_pad.sv
// Per-pin pad control: chooses peripheral, push-pull, open-drain or
// undriven behaviour from the configuration bits. Purely combinational.
module gpio_dp_pad #(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0] q_data,
    input  logic [N_PINS-1:0] q_dir,
    input  logic [N_PINS-1:0] q_alt,
    input  logic [N_PINS-1:0] q_den,
    input  logic [N_PINS-1:0] q_odr,
    input  logic [N_PINS-1:0] q_pup,
    input  logic [N_PINS-1:0] q_pdn,
    input  logic [N_PINS-1:0] alt_oe,
    input  logic [N_PINS-1:0] alt_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pu,
    output logic [N_PINS-1:0] pad_pd
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // Drive decision for pin i.
        always_comb begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = 1'b0;
            if (q_den[i]) begin
                if (q_alt[i]) begin
                    pad_oe[i]  = alt_oe[i];
                    pad_out[i] = alt_out[i];
                end else if (q_dir[i]) begin
                    if (q_odr[i]) begin
                        pad_oe[i]  = !q_data[i];
                    end else begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = q_data[i];
                    end
                end
            end
        end
        assign pad_pu[i] = q_den[i] & q_pup[i];
        assign pad_pd[i] = q_den[i] & q_pdn[i];
    end
endmodule

// File: rtl/gpio_dual_port.sv
// Top level of one GPIO port behind two bus windows. Wires the bus front
// end, register file and pad control together. Assumes ADDR_W = 8 layout
// (window bit on top, word index below, byte bits ignored).
module gpio_dual_port #(
    parameter int                N_PINS     = 8,
    parameter int                ADDR_W     = 8,
    parameter logic [N_PINS-1:0] DEBUG_MASK = N_PINS'(4'hF),
    parameter logic [31:0]       ID_MAGIC   = 32'h4750_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              win_fast_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] alt_oe,
    input  logic [N_PINS-1:0] alt_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_pu,
    output logic [N_PINS-1:0] pad_pd
);
    localparam int IDX_W = ADDR_W - 3;

    logic              acc_wr;
    logic [IDX_W-1:0]  acc_idx;
    logic [31:0]       acc_wdata;
    logic [31:0]       rd_value;
    logic              leg_busy;
    logic              addr_fast;
    logic [N_PINS-1:0] q_data, q_dir, q_alt, q_den, q_odr, q_pup, q_pdn;

    assign addr_fast = req_addr[ADDR_W-1];

    gpio_dp_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .win_fast_sel(win_fast_sel),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_value(rd_value), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .acc_wr(acc_wr), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .leg_busy(leg_busy)
    );

    gpio_dp_regs #(.N_PINS(N_PINS), .IDX_W(IDX_W), .DEBUG_MASK(DEBUG_MASK),
                   .ID_MAGIC(ID_MAGIC)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .pin_in(pin_in), .rd_value(rd_value),
        .q_data(q_data), .q_dir(q_dir), .q_alt(q_alt), .q_den(q_den),
        .q_odr(q_odr), .q_pup(q_pup), .q_pdn(q_pdn)
    );

    gpio_dp_pad #(.N_PINS(N_PINS)) u_pad (
        .q_data(q_data), .q_dir(q_dir), .q_alt(q_alt), .q_den(q_den),
        .q_odr(q_odr), .q_pup(q_pup), .q_pdn(q_pdn), .alt_oe(alt_oe),
        .alt_out(alt_out), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );
endmodule

// File: rtl/gpio_dp_chk.sv
// Checker for gpio_dual_port: handshake timing, dark-window reads,
// clock-enable gating and pad invariants. Bound into every instance.
module gpio_dp_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              win_fast_sel,
    input logic              req_valid,
    input logic              addr_fast,
    input logic              req_ready,
    input logic [31:0]       rsp_rdata,
    input logic              leg_busy,
    input logic [N_PINS-1:0] q_dir,
    input logic [N_PINS-1:0] q_den,
    input logic [N_PINS-1:0] q_alt,
    input logic [N_PINS-1:0] q_odr,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_pu,
    input logic [N_PINS-1:0] pad_pd
);
    AST_FAST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && addr_fast && !leg_busy |-> req_ready); // R2
    AST_SLOW_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !addr_fast && !leg_busy |-> !req_ready); // R3
    AST_SLOW_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        leg_busy |-> req_ready); // R3
    AST_SLOW_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        leg_busy |=> !leg_busy); // R3
    AST_DARK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && addr_fast && !leg_busy && (!clk_en || !win_fast_sel)
        |-> rsp_rdata == 32'h0); // R4
    AST_GATED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en) && $past(!clk_en, 2) |-> $stable(q_dir) && $stable(q_den)); // R5
    AST_NO_DRIVE_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~q_den) == '0); // R10
    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & q_odr & q_dir & ~q_alt) == '0); // R8
    AST_NO_PULL_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & ~q_den) == '0); // R10
endmodule

bind gpio_dual_port gpio_dp_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .win_fast_sel(win_fast_sel),
    .req_valid(req_valid), .addr_fast(addr_fast), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .leg_busy(leg_busy), .q_dir(q_dir), .q_den(q_den),
    .q_alt(q_alt), .q_odr(q_odr), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/sim_gpio_dual_port.sv
// Sweep bench for gpio_dual_port: every register through every
// window/select/enable combination, then a per-pin pad truth-table sweep.
module sim_gpio_dual_port;
    localparam int N = 8;
    localparam logic [7:0]  DBG   = 8'h0F;
    localparam logic [31:0] MAGIC = 32'h4750_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1, win_fast_sel = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic [N-1:0] pin_in = '0, alt_oe = '0, alt_out = '0;
    logic [N-1:0] pad_oe, pad_out, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_dual_port u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .win_fast_sel(win_fast_sel),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .pin_in(pin_in), .alt_oe(alt_oe), .alt_out(alt_out), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access; called at a falling edge, returns at a falling edge.
    task automatic xfer(input bit wr, input bit fast, input int idx, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {fast, idx[4:0], 2'b00};
        req_wdata = wd;
        cyc = 1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] id_exp(input int k);
        return MAGIC | k;
    endfunction

    initial begin
        int wd_cycles;
        wd_cycles = 0;
        while (wd_cycles < 150000 && !done) begin
            @(posedge clk);
            wd_cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        logic [7:0] model [7];
        logic [7:0] exp_oe, exp_out, exp_pu, exp_pd;
        logic [7:0] v_alt, v_den, v_dir, v_odr, v_pup, v_pdn, v_dat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        alt_oe = 8'hFF;
        alt_out = 8'hA5;
        #1;
        // R1: reset pads: only debug pins drive, taking peripheral values
        check("R1 oe", 32'(pad_oe), 32'(DBG));
        check("R1 out", 32'(pad_out), 32'(8'hA5 & DBG));
        check("R1 pull", 32'(pad_pu | pad_pd), 32'h0);
        @(negedge clk);
        for (int i = 1; i <= 6; i++) begin
            xfer(1'b0, 1'b1, i, 32'h0, rd, cyc);
            check("R1 reg", rd, (i == 2 || i == 3) ? 32'(DBG) : 32'h0);
        end
        model[0] = 8'h00; model[1] = 8'h00; model[2] = DBG; model[3] = DBG;
        model[4] = 8'h00; model[5] = 8'h00; model[6] = 8'h00;

        // R12: sampled pin reads
        pin_in = 8'h5A;
        @(negedge clk);
        xfer(1'b0, 1'b1, 0, 32'h0, rd, cyc);
        check("R12", rd, 32'h5A);
        pin_in = 8'hC3;
        @(negedge clk);
        xfer(1'b0, 1'b0, 0, 32'h0, rd, cyc);
        win_fast_sel = 1'b0;
        xfer(1'b0, 1'b0, 0, 32'h0, rd, cyc);
        check("R12 slow", rd, 32'hC3);
        win_fast_sel = 1'b1;
        pin_in = 8'h3C;

        // R2 R3 R4 R5 R6 R11: window x select x enable x index sweep
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int idx = 0; idx < 16; idx++) begin
                        logic [31:0] wd;
                        logic [31:0] exp;
                        bit live;
                        wd = 32'hDEAD_0000 | 32'((idx * 37 + f * 91 + s * 29 + e * 13) & 255);
                        live = (e == 1) && (f == s);
                        win_fast_sel = s[0];
                        clk_en = e[0];
                        xfer(1'b1, f[0], idx, wd, rd, cyc);
                        check(f ? "R2 latency" : "R3 latency", 32'(cyc), f ? 32'd1 : 32'd2);
                        if (live && idx <= 6) model[idx] = wd[7:0];
                        // read through the same (possibly dark) window
                        xfer(1'b0, f[0], idx, 32'h0, rd, cyc);
                        if (!live) check(e ? "R4 dark read" : "R5 gated read", rd, 32'h0);
                        // read back through the live window
                        clk_en = 1'b1;
                        xfer(1'b0, s[0], idx, 32'h0, rd, cyc);
                        if (idx == 0)                exp = 32'h3C;
                        else if (idx <= 6)           exp = 32'(model[idx]);
                        else if (idx >= 8 && idx < 12) exp = id_exp(idx - 8);
                        else                         exp = 32'h0;
                        if (idx >= 8 && idx < 12)   check("R11 id", rd, exp);
                        else if (!live)             check(e ? "R4 no write" : "R5 no write", rd, exp);
                        else                        check("R6 readback", rd, exp);
                    end
                end
            end
        end
        win_fast_sel = 1'b1;
        clk_en = 1'b1;

        // R7 R8 R9 R10: pad truth table, each pin a different combination
        for (int c = 0; c < 512; c++) begin
            for (int i = 0; i < N; i++) begin
                int cc;
                cc = (c + i * 67) % 512;
                v_alt[i] = cc[0]; v_den[i] = cc[1]; v_dir[i] = cc[2];
                v_odr[i] = cc[3]; v_pup[i] = cc[4]; v_pdn[i] = cc[5];
                v_dat[i] = cc[6]; alt_oe[i] = cc[7]; alt_out[i] = cc[8];
            end
            xfer(1'b1, 1'b1, 0, 32'(v_dat), rd, cyc);
            xfer(1'b1, 1'b1, 1, 32'(v_dir), rd, cyc);
            xfer(1'b1, 1'b1, 2, 32'(v_alt), rd, cyc);
            xfer(1'b1, 1'b1, 3, 32'(v_den), rd, cyc);
            xfer(1'b1, 1'b1, 4, 32'(v_odr), rd, cyc);
            xfer(1'b1, 1'b1, 5, 32'(v_pup), rd, cyc);
            xfer(1'b1, 1'b1, 6, 32'(v_pdn), rd, cyc);
            #1;
            for (int i = 0; i < N; i++) begin
                exp_oe[i] = 1'b0;
                exp_out[i] = 1'b0;
                if (v_den[i] && v_alt[i]) begin
                    exp_oe[i] = alt_oe[i]; exp_out[i] = alt_out[i];
                end else if (v_den[i] && v_dir[i] && v_odr[i]) begin
                    exp_oe[i] = ~v_dat[i];
                end else if (v_den[i] && v_dir[i]) begin
                    exp_oe[i] = 1'b1; exp_out[i] = v_dat[i];
                end
            end
            exp_pu = v_den & v_pup;
            exp_pd = v_den & v_pdn;
            check("R7 R8 R9 oe", 32'(pad_oe), 32'(exp_oe));
            check("R7 R8 R9 out", 32'(pad_out), 32'(exp_out));
            check("R10 pu", 32'(pad_pu), 32'(exp_pu));
            check("R10 pd", 32'(pad_pd), 32'(exp_pd));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule